// File: doc/BRIEF.md
# Block Erase Sequencer with Pause Point

This block runs the internal, timed erase algorithm for one block of a small behavioural storage array. A single start pulse, with a block index and a supply-good flag, launches the algorithm. The algorithm first drives every word of the chosen block to all zeros and checks the result. It then drives every word to all ones and checks that result too. Each of the four phases is made of one step per word, and every step lasts a fixed, parameterised number of clock cycles. A write strobe marks the end of each write step and a verify strobe marks the end of each check step.

A host can ask the sequencer to pause. The request is held until the current step ends, because the step boundary is the only point where the algorithm may stop. At that boundary the sequencer reports that it is suspended, and it stays there until a resume request arrives. It then carries on from the step that follows the pause. Other blocks can be read at any time through a read channel. Reads of the block under erase are refused while the erase is busy or suspended.

A failed check repeats the phase pair it belongs to, up to a retry limit. Once the limit is used up, the sequencer ends with a failure. The `vfy_fault_i` input forces a check to fail so that this path can be exercised. The parameters `NUM_BLOCKS` and `BLOCK_WORDS` must be powers of two.

Top module: `erase_sequencer`

## Requirements
- R1: After an accepted start with supply good, no fault and no pause, the sequencer runs four phases in this order: BLOCK_WORDS write strobes that store zeros, BLOCK_WORDS verify strobes, BLOCK_WORDS write strobes that store all ones, and BLOCK_WORDS verify strobes. `done_o` is high for one cycle, exactly 4*BLOCK_WORDS*STEP_CYCLES clock edges after the edge that accepted the start.
- R2: After reset, the word at flat address a (block*BLOCK_WORDS + word) holds (a*37+5) mod 2^DATA_W. A successful erase leaves every word of the selected block all ones and leaves every other block unchanged.
- R3: A start accepted while `supply_ok_i` is low runs no phase. `busy_o` stays low, and on the very edge that accepts the start, `done_o`, `fail_o` and `supply_err_o` are set. The array is not touched.
- R4: A pause request made in the middle of a step takes effect at the next step boundary. `suspended_o` rises at that edge, stays high until a resume request, and no strobe is produced while suspended.
- R5: After a resume the sequence continues where it stopped. It still produces the full 4*BLOCK_WORDS strobes and leaves the block all ones. The total time to `done_o` is the normal time plus the number of cycles spent suspended.
- R6: While the sequencer is busy or suspended, a read whose block field equals the block under erase sees `rd_ready_o` low. Reads of any other block are accepted and return the stored data.
- R7: A verify step that sees a mismatch or `vfy_fault_i` high marks its phase as bad. At the end of a bad phase, that write phase and its check are repeated, up to MAX_RETRY times. After that, the sequencer ends with `fail_o` high and `busy_o` low. `fail_o` holds until the next accepted start.
- R8: A start pulse while busy, a resume pulse while not suspended, and a pause pulse while idle all have no effect. In particular they do not change the timing or the result of the current or next erase.
- R9: Out of reset, `busy_o`, `suspended_o`, `done_o`, `fail_o`, `supply_err_o` and `rsp_valid_o` are low and `rd_ready_o` is high.
- R10: A read handshake (`rd_valid_i` and `rd_ready_o` both high) yields `rsp_valid_o` with the data on the following cycle. The response side has no back-pressure, so the host must take the data that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Erase start pulse, taken only when idle |
| suspend_i | input | 1 | Pause request |
| resume_i | input | 1 | Resume request, taken only when suspended |
| blk_i | input | BW | Block to erase, latched at start |
| supply_ok_i | input | 1 | Programming supply within limits |
| vfy_fault_i | input | 1 | Forces a verify step to fail |
| rd_valid_i | input | 1 | Read request valid |
| rd_addr_i | input | AW | Read address, block in upper bits |
| rd_ready_o | output | 1 | Read request accepted |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | DATA_W | Read data |
| busy_o | output | 1 | Erase in progress, including while suspended |
| suspended_o | output | 1 | Sequencer parked at a pause point |
| done_o | output | 1 | One-cycle end-of-erase pulse |
| fail_o | output | 1 | Last erase failed |
| supply_err_o | output | 1 | Last erase was refused because of the supply |
| wr_stb_o | output | 1 | Array write strobe |
| vfy_stb_o | output | 1 | Verify strobe |

## Verification
The assertions assume that reset is applied before the first edge, that `rd_valid_i` is low during reset, and that the control pulses are single-cycle and synchronous to the clock. The response property also assumes the host never needs back-pressure. The bench keeps to these assumptions: it drives every input at the falling edge, keeps the read request low in reset, and raises each control pulse for one cycle only. It also starts an erase only when the scoreboard queue is empty, except for the deliberate start-while-busy case. That case is not pushed to the scoreboard, so a spurious second completion would appear as an unexpected done.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PROG,
    SQ_PVFY,
    SQ_ERASE,
    SQ_EVFY,
    SQ_SUSP
  } sq_state_t;

  // reset contents of the array at flat address a
  function automatic int unsigned seed_word(int unsigned a);
    return a * 37 + 5;
  endfunction

endpackage

// File: rtl/erase_step_timer.sv
module erase_step_timer #(
  parameter int STEP_CYCLES = 3,
  parameter int WORDS = 4,
  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  output logic          step_end,
  output logic          last_word,
  output logic [WW-1:0] word_idx
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;

  logic [CW-1:0] cyc_q;

  assign step_end  = run && (cyc_q == CW'(STEP_CYCLES - 1));
  assign last_word = (word_idx == WW'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= '0;
      word_idx <= '0;
    end else if (clear) begin
      cyc_q    <= '0;
      word_idx <= '0;
    end else if (run) begin
      if (step_end) begin
        cyc_q    <= '0;
        word_idx <= last_word ? '0 : word_idx + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/erase_array.sv
module erase_array #(
  parameter int DEPTH = 16,
  parameter int DATA_W = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     vfy_addr,
  output logic [DATA_W-1:0] vfy_data,
  input  logic              rd_fire,
  input  logic [AW-1:0]     rd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  import erase_seq_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];

  assign vfy_data = mem[vfy_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(seed_word(i));
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl #(
  parameter int NUM_BLOCKS = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int DATA_W = 8,
  parameter int MAX_RETRY = 2,
  localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int WW = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic [BW-1:0]     blk_in,
  input  logic              supply_ok,
  input  logic              vfy_fault,
  input  logic              step_end,
  input  logic              last_word,
  input  logic [WW-1:0]     word_idx,
  input  logic [DATA_W-1:0] vfy_data,
  output logic              run,
  output logic              tclear,
  output logic              busy,
  output logic              suspended,
  output logic              done,
  output logic              fail,
  output logic              supply_err,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              vfy_stb,
  output logic [BW-1:0]     cur_blk
);
  import erase_seq_pkg::*;

  localparam int RW = $clog2(MAX_RETRY + 1) > 0 ? $clog2(MAX_RETRY + 1) : 1;

  sq_state_t     state, saved, nxt;
  logic          pend;
  logic          bad;
  logic [RW-1:0] retries;
  logic          writing, verifying, mism, bad_now;
  logic          fin, fin_bad, retry_go, phase_pass;
  logic [DATA_W-1:0] vfy_exp;

  assign writing   = (state == SQ_PROG) || (state == SQ_ERASE);
  assign verifying = (state == SQ_PVFY) || (state == SQ_EVFY);
  assign run       = writing || verifying;
  assign busy      = (state != SQ_IDLE);
  assign suspended = (state == SQ_SUSP);
  assign tclear    = start && (state == SQ_IDLE);
  assign wr_en     = writing && step_end;
  assign wr_data   = (state == SQ_ERASE) ? '1 : '0;
  assign vfy_stb   = verifying && step_end;
  assign vfy_exp   = (state == SQ_EVFY) ? '1 : '0;
  assign mism      = vfy_fault || (vfy_data != vfy_exp);
  assign bad_now   = bad || (verifying && mism);

  always_comb begin
    nxt        = state;
    fin        = 1'b0;
    fin_bad    = 1'b0;
    retry_go   = 1'b0;
    phase_pass = 1'b0;
    unique case (state)
      SQ_PROG:  if (last_word) nxt = SQ_PVFY;
      SQ_ERASE: if (last_word) nxt = SQ_EVFY;
      SQ_PVFY, SQ_EVFY: begin
        if (last_word) begin
          if (!bad_now) begin
            phase_pass = 1'b1;
            if (state == SQ_PVFY) nxt = SQ_ERASE;
            else begin
              fin = 1'b1;
              nxt = SQ_IDLE;
            end
          end else if (retries < RW'(MAX_RETRY)) begin
            retry_go = 1'b1;
            nxt = (state == SQ_PVFY) ? SQ_PROG : SQ_ERASE;
          end else begin
            fin     = 1'b1;
            fin_bad = 1'b1;
            nxt     = SQ_IDLE;
          end
        end
      end
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      saved      <= SQ_IDLE;
      pend       <= 1'b0;
      bad        <= 1'b0;
      retries    <= '0;
      done       <= 1'b0;
      fail       <= 1'b0;
      supply_err <= 1'b0;
      cur_blk    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          pend <= 1'b0;
          if (start) begin
            cur_blk    <= blk_in;
            retries    <= '0;
            bad        <= 1'b0;
            fail       <= 1'b0;
            supply_err <= 1'b0;
            if (!supply_ok) begin
              fail       <= 1'b1;
              supply_err <= 1'b1;
              done       <= 1'b1;
            end else begin
              state <= SQ_PROG;
            end
          end
        end
        SQ_SUSP: begin
          if (resume_req) state <= saved;
        end
        default: begin
          if (suspend_req) pend <= 1'b1;
          if (step_end) begin
            if (verifying) bad <= last_word ? 1'b0 : bad_now;
            if (retry_go) retries <= retries + 1'b1;
            else if (phase_pass) retries <= '0;
            if (fin) begin
              state <= SQ_IDLE;
              done  <= 1'b1;
              fail  <= fin_bad;
              pend  <= 1'b0;
            end else if (pend || suspend_req) begin
              state <= SQ_SUSP;
              saved <= nxt;
              pend  <= 1'b0;
            end else begin
              state <= nxt;
            end
          end
        end
      endcase
    end
  end

  logic unused_word;
  assign unused_word = ^word_idx;
endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer #(
  parameter int NUM_BLOCKS = 4,
  parameter int BLOCK_WORDS = 4,
  parameter int DATA_W = 8,
  parameter int STEP_CYCLES = 3,
  parameter int MAX_RETRY = 2,
  localparam int BW = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int WW = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1,
  localparam int AW = BW + WW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic [BW-1:0]     blk_i,
  input  logic              supply_ok_i,
  input  logic              vfy_fault_i,
  input  logic              rd_valid_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic              rd_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              busy_o,
  output logic              suspended_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              supply_err_o,
  output logic              wr_stb_o,
  output logic              vfy_stb_o
);
  localparam int DEPTH = NUM_BLOCKS * BLOCK_WORDS;

  logic              run, tclear, step_end, last_word;
  logic [WW-1:0]     word_idx;
  logic [BW-1:0]     cur_blk;
  logic [DATA_W-1:0] wr_data, vfy_data;
  logic [AW-1:0]     seq_addr;
  logic              rd_fire;

  assign seq_addr   = {cur_blk, word_idx};
  assign rd_ready_o = !(busy_o && (rd_addr_i[AW-1 -: BW] == cur_blk));
  assign rd_fire    = rd_valid_i && rd_ready_o;

  erase_step_timer #(
    .STEP_CYCLES(STEP_CYCLES),
    .WORDS      (BLOCK_WORDS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tclear),
    .run      (run),
    .step_end (step_end),
    .last_word(last_word),
    .word_idx (word_idx)
  );

  erase_ctrl #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_WORDS(BLOCK_WORDS),
    .DATA_W     (DATA_W),
    .MAX_RETRY  (MAX_RETRY)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .suspend_req(suspend_i),
    .resume_req (resume_i),
    .blk_in     (blk_i),
    .supply_ok  (supply_ok_i),
    .vfy_fault  (vfy_fault_i),
    .step_end   (step_end),
    .last_word  (last_word),
    .word_idx   (word_idx),
    .vfy_data   (vfy_data),
    .run        (run),
    .tclear     (tclear),
    .busy       (busy_o),
    .suspended  (suspended_o),
    .done       (done_o),
    .fail       (fail_o),
    .supply_err (supply_err_o),
    .wr_en      (wr_stb_o),
    .wr_data    (wr_data),
    .vfy_stb    (vfy_stb_o),
    .cur_blk    (cur_blk)
  );

  erase_array #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_stb_o),
    .wr_addr  (seq_addr),
    .wr_data  (wr_data),
    .vfy_addr (seq_addr),
    .vfy_data (vfy_data),
    .rd_fire  (rd_fire),
    .rd_addr  (rd_addr_i),
    .rsp_valid(rsp_valid_o),
    .rsp_data (rsp_data_o)
  );
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic resume,
  input logic supply_ok,
  input logic busy,
  input logic suspended,
  input logic done,
  input logic fail,
  input logic supply_err,
  input logic wr_stb,
  input logic vfy_stb,
  input logic rd_valid,
  input logic rd_ready,
  input logic rsp_valid
);
  a_r1_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && vfy_stb));

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(wr_stb || vfy_stb));

  a_r3_supply_refused: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !supply_ok |=> done && fail && supply_err && !busy);

  a_r4_no_strobe_paused: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !(wr_stb || vfy_stb));

  a_r4_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !resume |=> suspended);

  a_r5_resume_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && resume |=> !suspended && busy);

  a_r6_refuse_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |-> busy);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_idle_resume: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && resume && !start |=> !busy && !suspended);

  a_r9_pause_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> busy);

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> rsp_valid);

  a_r10_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_valid && rd_ready));
endmodule

bind erase_sequencer erase_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start_i),
  .resume    (resume_i),
  .supply_ok (supply_ok_i),
  .busy      (busy_o),
  .suspended (suspended_o),
  .done      (done_o),
  .fail      (fail_o),
  .supply_err(supply_err_o),
  .wr_stb    (wr_stb_o),
  .vfy_stb   (vfy_stb_o),
  .rd_valid  (rd_valid_i),
  .rd_ready  (rd_ready_o),
  .rsp_valid (rsp_valid_o)
);

// File: tb/erase_sequencer_bench.sv
`timescale 1ns/1ps
module erase_sequencer_bench;
  localparam int NB = 4;
  localparam int WPB = 4;
  localparam int DW = 8;
  localparam int SC = 3;
  localparam int MR = 2;
  localparam int BW = 2;
  localparam int AW = 4;
  localparam int FULL = 4 * WPB * SC;
  localparam int ONES = (1 << DW) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, suspend = 0, resume = 0, supply_ok = 1, fault = 0;
  logic [BW-1:0] blk = '0;
  logic rd_valid = 0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_ready, rsp_valid, busy, suspended, done, fail, serr, wr_stb, vfy_stb;
  logic [DW-1:0] rsp_data;

  always #2.5 clk = ~clk;

  erase_sequencer #(
    .NUM_BLOCKS(NB), .BLOCK_WORDS(WPB), .DATA_W(DW), .STEP_CYCLES(SC), .MAX_RETRY(MR)
  ) u_erase_sequencer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .suspend_i(suspend), .resume_i(resume),
    .blk_i(blk), .supply_ok_i(supply_ok), .vfy_fault_i(fault),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_ready_o(rd_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .busy_o(busy),
    .suspended_o(suspended), .done_o(done), .fail_o(fail), .supply_err_o(serr),
    .wr_stb_o(wr_stb), .vfy_stb_o(vfy_stb)
  );

  typedef struct {
    int t0; int lat; bit f; bit s; int nwr; int nvf; string req;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  int cyc = 0;
  int susp_cnt = 0, wr_cnt = 0, vf_cnt = 0;
  int last_t0 = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int seed(int a);
    return (a * 37 + 5) & ONES;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each completion pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (suspended) susp_cnt++;
      if (wr_stb) wr_cnt++;
      if (vfy_stb) vf_cnt++;
      if (done) begin
        if (q.size() == 0) chk(0, "R8", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk((cyc - e.t0 - 1 - susp_cnt) == e.lat, e.req, "latency", cyc - e.t0 - 1 - susp_cnt, e.lat);
          chk(fail == e.f, e.req, "fail", fail, e.f);
          chk(serr == e.s, e.req, "supply_err", serr, e.s);
          chk(wr_cnt == e.nwr, e.req, "write strobes", wr_cnt, e.nwr);
          chk(vf_cnt == e.nvf, e.req, "verify strobes", vf_cnt, e.nvf);
        end
      end
    end
  end

  // driver: pulses start and pushes the expected completion
  task automatic launch(input int b, input int lat, input bit f, input bit s,
                        input int nwr, input int nvf, input string req);
    exp_t e;
    @(negedge clk);
    start = 1; blk = BW'(b);
    e.t0 = cyc; e.lat = lat; e.f = f; e.s = s; e.nwr = nwr; e.nvf = nvf; e.req = req;
    last_t0 = cyc;
    susp_cnt = 0; wr_cnt = 0; vf_cnt = 0;
    q.push_back(e);
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd_word(input int addr, input bit exp_rdy, input int exp_data, input string req);
    @(negedge clk);
    rd_valid = 1; rd_addr = AW'(addr);
    #1;
    chk(rd_ready == exp_rdy, req, "rd_ready", rd_ready, exp_rdy);
    @(negedge clk);
    rd_valid = 0;
    chk(rsp_valid == exp_rdy, req, "rsp_valid", rsp_valid, exp_rdy);
    if (exp_rdy) chk(rsp_data == exp_data[DW-1:0], req, "rsp_data", rsp_data, exp_data);
  endtask

  task automatic pulse_resume();
    @(negedge clk); resume = 1; @(negedge clk); resume = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0, es, expe, g;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !suspended && !done, "R9", "busy/susp/done", busy, 0);
    chk(!fail && !serr && !rsp_valid, "R9", "fail/serr/rsp", fail, 0);
    chk(rd_ready == 1, "R9", "rd_ready", rd_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !fail, "R9", "after release", busy, 0);
    rd_word(5, 1, seed(5), "R2");
    rd_word(14, 1, seed(14), "R10");

    // R1 plain erase of block 1
    launch(1, FULL, 0, 0, 2 * WPB, 2 * WPB, "R1");
    wait_idle();
    for (int w = 0; w < WPB; w++) rd_word(1 * WPB + w, 1, ONES, "R2");
    rd_word(0, 1, seed(0), "R2");
    rd_word(9, 1, seed(9), "R2");

    // R8 start and resume while busy are ignored
    launch(2, FULL, 0, 0, 2 * WPB, 2 * WPB, "R8");
    repeat (5) @(negedge clk);
    start = 1; blk = 2'd3;
    @(negedge clk); start = 0;
    pulse_resume();
    chk(suspended == 0, "R8", "resume without pause", suspended, 0);
    wait_idle();
    rd_word(3 * WPB, 1, seed(3 * WPB), "R8");
    rd_word(2 * WPB + 3, 1, ONES, "R8");

    // R4/R5/R6 pause mid-step on block 0
    launch(0, FULL, 0, 0, 2 * WPB, 2 * WPB, "R5");
    e0 = last_t0 + 1;
    repeat (4) @(negedge clk);
    suspend = 1; es = cyc + 1;
    @(negedge clk); suspend = 0;
    expe = e0 + SC * ((es - e0 + SC - 1) / SC);
    chk(suspended == 0, "R4", "not paused mid-step", suspended, 0);
    g = 0;
    while (!suspended && g < 100) begin @(negedge clk); g++; end
    chk(cyc == expe, "R4", "pause edge", cyc, expe);
    rd_word(0 * WPB + 1, 0, 0, "R6");
    rd_word(3 * WPB + 2, 1, seed(3 * WPB + 2), "R6");
    @(negedge clk); suspend = 1; @(negedge clk); suspend = 0;
    repeat (2) @(negedge clk);
    chk(suspended == 1, "R4", "stays paused", suspended, 1);
    chk(busy == 1, "R4", "busy while paused", busy, 1);
    pulse_resume();
    chk(suspended == 0, "R5", "resumed", suspended, 0);
    wait_idle();
    for (int w = 0; w < WPB; w++) rd_word(w, 1, ONES, "R5");

    // R3 supply refused
    supply_ok = 0;
    launch(3, 0, 1, 1, 0, 0, "R3");
    chk(busy == 0, "R3", "busy stays low", busy, 0);
    supply_ok = 1;
    wait_idle();
    rd_word(3 * WPB + 1, 1, seed(3 * WPB + 1), "R3");

    // R7 one faulted verify phase then success
    fault = 1;
    launch(2, 6 * WPB * SC, 0, 0, 3 * WPB, 3 * WPB, "R7");
    repeat ((WPB + 2) * SC) @(negedge clk);
    fault = 0;
    wait_idle();
    rd_word(2 * WPB, 1, ONES, "R7");

    // R7 persistent fault exhausts the retries
    fault = 1;
    launch(3, (MR + 1) * 2 * WPB * SC, 1, 0, (MR + 1) * WPB, (MR + 1) * WPB, "R7");
    wait_idle();
    fault = 0;
    chk(fail == 1 && busy == 0, "R7", "fail held, not busy", fail, 1);
    rd_word(3 * WPB + 2, 1, 0, "R7");

    // R8 pause and resume pulses while idle are ignored
    @(negedge clk); suspend = 1; @(negedge clk); suspend = 0;
    pulse_resume();
    chk(!busy && !suspended, "R8", "idle pulses", busy, 0);
    launch(3, FULL, 0, 0, 2 * WPB, 2 * WPB, "R8");
    wait_idle();
    rd_word(3 * WPB + 2, 1, ONES, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule